// File: doc/BRIEF.md
# PWM Compare Timer with Interrupts

This block is a counter-based timer. A 16-bit up-counter advances by one on each cycle where the external `tick` strobe is high and the run bit is set. Two compare registers watch the count.

With counter-clear mode on, a match on compare 1 returns the counter to zero, so compare 1 sets the waveform period. In PWM mode, a match on either compare applies a two-bit action code to the `pwmOut` pin. Compare 0 sets the off time of that waveform.

The block keeps sticky status flags for the following events:
- a match on compare 0;
- a match on compare 1;
- a counter overflow;
- each capture strobe, with a parameterized number of capture inputs.

Software clears a flag by writing a one to it. A per-flag enable mask gates the flags onto a single level interrupt. Each capture strobe also stores the value on `capVal` into that channel's capture register. Software reaches all state through a plain synchronous register port.

Top module: `pwm_cmp_timer`

## Requirements
- R1: After reset, the following are all zero: the control register, both compare registers, the count, the status flags, the enable mask, `pwmOut` and `irq`.
- R2: The count changes only in two cases. It rises by one on a cycle with `tick`=1 while control bit 0 (run) is 1. It is also loaded directly by a write to the count register. Without these, it holds.
- R3: Control bit 2 (clear mode) can be 1. In that case, a tick while the count equals compare 1 makes the next count 0, so the period is compare 1 + 1 ticks. With clear mode 0 the counter runs freely past compare 1.
- R4: Set control bit 1 (PWM enable) to 1, the compare-0 action (control bits 4:3) to 10, the compare-1 action (bits 6:5) to 01, compare 1 to 5 and compare 0 to 1. The output is then low while the count is 0 or 1 and high while it is 2 to 5. This gives a period of 6 ticks and an off time of 2 ticks.
- R5: The action codes are 00 no change, 01 drive low, 10 drive high and 11 toggle. A code takes effect on the tick in which its compare matches. If both compares match on the same tick, only the compare-1 action applies.
- R6: While PWM enable is 0, `pwmOut` keeps its last value whatever the compares do.
- R7: The overflow flag (status bit 2) is set when a tick wraps the count from 0xFFFF to 0 with clear mode off. It is never set while clear mode is on.
- R8: Status bit 0 is set on a ticked compare-0 match and status bit 1 on a ticked compare-1 match. Each flag is set whatever the enable mask holds.
- R9: Capture strobe i stores `capVal` into capture register i (address 8+i) and sets status bit 3+i. Several strobes in one cycle are all taken. Up to 8 channels are allowed.
- R10: Writing status (address 4) clears each flag whose data bit is 1 and leaves the other flags alone. An event in the same cycle as its clear leaves the flag set. No flag clears by any other means.
- R11: `irq` is 1 exactly when some status flag and its enable bit (address 5, same bit layout) are both 1. It stays 1 until each such flag is cleared or disabled.
- R12: The register addresses are: control 0, compare 0 at 1, compare 1 at 2, count 3 (read/write), status 4, enable 5, and capture registers from 8. A read with `rdEn` returns the value on `rdData` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-enable strobe |
| addr | input | 4 | Register address |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 16 | Register write data |
| rdEn | input | 1 | Register read strobe |
| rdData | output | 16 | Registered read data |
| capStb | input | 5 | Capture strobes, one per channel |
| capVal | input | 16 | Value stored by a capture strobe |
| pwmOut | output | 1 | PWM output pin |
| irq | output | 1 | Combined level interrupt |

## Verification
Two collisions matter in this block. The first is a capture event and a write-one-to-clear of its own status flag in the same cycle: the bench raises `capStb[0]` in the very cycle it writes 0x08 to status, then reads status and expects the flag still set. The second is both compares matching on one tick: with both compares set to 3, the compare-0 code drives low and the compare-1 code drives high, and the bench expects a high output after that tick. A design that let compare 0 win would show low.

// File: rtl/pwm_cmp_timer_pkg.sv
package pwm_cmp_timer_pkg;

  localparam int unsigned ADDR_W = 4;
  localparam int unsigned CTRL_W = 7;

  localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
  localparam logic [ADDR_W-1:0] A_CMP0     = 4'd1;
  localparam logic [ADDR_W-1:0] A_CMP1     = 4'd2;
  localparam logic [ADDR_W-1:0] A_COUNT    = 4'd3;
  localparam logic [ADDR_W-1:0] A_STATUS   = 4'd4;
  localparam logic [ADDR_W-1:0] A_INTEN    = 4'd5;
  localparam logic [ADDR_W-1:0] A_CAP_BASE = 4'd8;

  // status bit positions
  localparam int unsigned ST_CMP0 = 0;
  localparam int unsigned ST_CMP1 = 1;
  localparam int unsigned ST_OVF  = 2;
  localparam int unsigned ST_CAP0 = 3;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_e;

  // strobes and settings from control to datapath
  typedef struct packed {
    logic step;
    logic load;
    logic pwmEn;
    logic clrMode;
    act_e act0;
    act_e act1;
  } dp_ctl_t;

  // events from datapath back to control
  typedef struct packed {
    logic hit0;
    logic hit1;
    logic wrap;
  } dp_evt_t;

endpackage

// File: rtl/timer_datapath.sv
module timer_datapath
  import pwm_cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_ctl_t          ctl,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] cmp0Val,
  input  logic [CNT_W-1:0] cmp1Val,
  output logic [CNT_W-1:0] countVal,
  output logic             pwmOut,
  output dp_evt_t          evt
);

  logic [CNT_W-1:0] countNext;
  logic             pwmNext;
  logic             atTop;

  function automatic logic applyAct(act_e a, logic cur);
    case (a)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

  always_comb begin
    atTop    = &countVal;
    evt.hit0 = ctl.step && (countVal == cmp0Val);
    evt.hit1 = ctl.step && (countVal == cmp1Val);
    evt.wrap = ctl.step && !ctl.clrMode && atTop;
  end

  always_comb begin
    countNext = countVal;
    if (ctl.load) begin
      countNext = loadVal;
    end else if (ctl.step) begin
      if (ctl.clrMode && evt.hit1) countNext = '0;
      else                         countNext = countVal + CNT_W'(1);
    end
  end

  // compare 1 takes priority when both match
  always_comb begin
    pwmNext = pwmOut;
    if (ctl.pwmEn) begin
      if (evt.hit1)      pwmNext = applyAct(ctl.act1, pwmOut);
      else if (evt.hit0) pwmNext = applyAct(ctl.act0, pwmOut);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
      pwmOut   <= 1'b0;
    end else begin
      countVal <= countNext;
      pwmOut   <= pwmNext;
    end
  end

endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import pwm_cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_CAP = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       tick,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       wrEn,
  input  logic [CNT_W-1:0]           wrData,
  input  logic                       rdEn,
  output logic [CNT_W-1:0]           rdData,
  input  logic [NUM_CAP-1:0]         capStb,
  input  logic [CNT_W-1:0]           capVal,
  input  dp_evt_t                    evt,
  input  logic [CNT_W-1:0]           countVal,
  output dp_ctl_t                    ctl,
  output logic [CNT_W-1:0]           cmp0Val,
  output logic [CNT_W-1:0]           cmp1Val,
  output logic [ST_CAP0+NUM_CAP-1:0] statusVal,
  output logic                       irq
);

  localparam int unsigned STAT_W = ST_CAP0 + NUM_CAP;

  logic [CTRL_W-1:0] ctrlQ;
  logic [STAT_W-1:0] intenQ;
  logic [STAT_W-1:0] evVec;
  logic [STAT_W-1:0] clrVec;
  logic [STAT_W-1:0] statusNext;
  logic [CNT_W-1:0]  capQ [NUM_CAP];
  logic [CNT_W-1:0]  rdNext;

  // control fields: [0] run, [1] pwm, [2] clear mode, [4:3] act0, [6:5] act1
  always_comb begin
    ctl.step    = tick && ctrlQ[0];
    ctl.load    = wrEn && (addr == A_COUNT);
    ctl.pwmEn   = ctrlQ[1];
    ctl.clrMode = ctrlQ[2];
    ctl.act0    = act_e'(ctrlQ[4:3]);
    ctl.act1    = act_e'(ctrlQ[6:5]);
  end

  // events set flags after the clear mask, so an event beats its clear
  always_comb begin
    evVec      = {capStb, evt.wrap, evt.hit1, evt.hit0};
    clrVec     = (wrEn && (addr == A_STATUS)) ? wrData[STAT_W-1:0] : '0;
    statusNext = (statusVal & ~clrVec) | evVec;
  end

  assign irq = |(statusVal & intenQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ     <= '0;
      cmp0Val   <= '0;
      cmp1Val   <= '0;
      intenQ    <= '0;
      statusVal <= '0;
    end else begin
      statusVal <= statusNext;
      if (wrEn) begin
        case (addr)
          A_CTRL:  ctrlQ   <= wrData[CTRL_W-1:0];
          A_CMP0:  cmp0Val <= wrData;
          A_CMP1:  cmp1Val <= wrData;
          A_INTEN: intenQ  <= wrData[STAT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NUM_CAP; g++) begin : gCap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          capQ[g] <= '0;
      else if (capStb[g]) capQ[g] <= capVal;
    end
  end

  always_comb begin
    rdNext = '0;
    case (addr)
      A_CTRL:   rdNext = CNT_W'(ctrlQ);
      A_CMP0:   rdNext = cmp0Val;
      A_CMP1:   rdNext = cmp1Val;
      A_COUNT:  rdNext = countVal;
      A_STATUS: rdNext = CNT_W'(statusVal);
      A_INTEN:  rdNext = CNT_W'(intenQ);
      default: begin
        for (int i = 0; i < NUM_CAP; i++) begin
          if (addr == (A_CAP_BASE | ADDR_W'(i))) rdNext = capQ[i];
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdNext;
  end

endmodule

// File: rtl/pwm_cmp_timer.sv
module pwm_cmp_timer
  import pwm_cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_CAP = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wrEn,
  input  logic [CNT_W-1:0]   wrData,
  input  logic               rdEn,
  output logic [CNT_W-1:0]   rdData,
  input  logic [NUM_CAP-1:0] capStb,
  input  logic [CNT_W-1:0]   capVal,
  output logic               pwmOut,
  output logic               irq
);

  localparam int unsigned STAT_W = ST_CAP0 + NUM_CAP;

  dp_ctl_t           dpCtl;
  dp_evt_t           dpEvt;
  logic [CNT_W-1:0]  countVal;
  logic [CNT_W-1:0]  cmp0Val;
  logic [CNT_W-1:0]  cmp1Val;
  logic [STAT_W-1:0] statusVal;

  timer_ctrl #(.CNT_W(CNT_W), .NUM_CAP(NUM_CAP)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .capStb(capStb),
    .capVal(capVal), .evt(dpEvt), .countVal(countVal), .ctl(dpCtl),
    .cmp0Val(cmp0Val), .cmp1Val(cmp1Val), .statusVal(statusVal), .irq(irq)
  );

  timer_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .loadVal(wrData),
    .cmp0Val(cmp0Val), .cmp1Val(cmp1Val), .countVal(countVal),
    .pwmOut(pwmOut), .evt(dpEvt)
  );

endmodule

// File: rtl/pwm_cmp_timer_chk.sv
module pwm_cmp_timer_chk
  import pwm_cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_CAP = 5
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       tick,
  input logic [ADDR_W-1:0]          addr,
  input logic                       wrEn,
  input logic [NUM_CAP-1:0]         capStb,
  input logic                       pwmOut,
  input logic                       irq,
  input logic [CNT_W-1:0]           countVal,
  input logic [CNT_W-1:0]           cmp1Val,
  input logic [ST_CAP0+NUM_CAP-1:0] statusVal,
  input logic                       stepIn,
  input logic                       pwmOn,
  input logic                       clrOn
);

  localparam int unsigned STAT_W = ST_CAP0 + NUM_CAP;

  a_r2_count_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !(wrEn && addr == A_COUNT)) |=> $stable(countVal));

  a_r3_clear_on_match: assert property (@(posedge clk) disable iff (!rstN)
    (stepIn && clrOn && countVal == cmp1Val && !(wrEn && addr == A_COUNT))
      |=> (countVal == '0));

  a_r6_hold_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !pwmOn |=> $stable(pwmOut));

  a_r7_no_ovf_clear_mode: assert property (@(posedge clk) disable iff (!rstN)
    (clrOn && !statusVal[ST_OVF]) |=> !statusVal[ST_OVF]);

  a_r9_cap_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    (capStb != '0) |=>
      ((statusVal[STAT_W-1:ST_CAP0] & $past(capStb)) == $past(capStb)));

  a_r10_flags_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ((statusVal & $past(statusVal)) == $past(statusVal)));

  a_r11_irq_level: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !wrEn) |=> irq);

endmodule

bind pwm_cmp_timer pwm_cmp_timer_chk #(.CNT_W(CNT_W), .NUM_CAP(NUM_CAP)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .addr(addr), .wrEn(wrEn),
  .capStb(capStb), .pwmOut(pwmOut), .irq(irq), .countVal(countVal),
  .cmp1Val(cmp1Val), .statusVal(statusVal), .stepIn(dpCtl.step),
  .pwmOn(dpCtl.pwmEn), .clrOn(dpCtl.clrMode)
);

// File: tb/pwm_cmp_timer_tb.sv
`timescale 1ns/1ps
module pwm_cmp_timer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic [3:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [15:0] rdData;
  logic [4:0]  capStb = '0;
  logic [15:0] capVal = '0;
  logic        pwmOut;
  logic        irq;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  logic [15:0] expQ[$];
  string       tagQ[$];
  logic        rdFire = 1'b0;

  always #5 clk = ~clk;

  pwm_cmp_timer u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .capStb(capStb),
    .capVal(capVal), .pwmOut(pwmOut), .irq(irq)
  );

  task automatic checkEq(string tag, logic [15:0] act, logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected item for each completed read
  always @(posedge clk) rdFire <= rdEn;
  always @(negedge clk) begin
    if (rdFire) begin
      if (expQ.size() == 0) begin
        nTests++; nFail++;
        $display("FAIL R12 scoreboard: act=%h exp=none", rdData);
      end else begin
        checkEq(tagQ.pop_front(), rdData, expQ.pop_front());
      end
    end
  end

  task automatic wrReg(logic [3:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdReg(logic [3:0] a, logic [15:0] exp, string tag);
    @(negedge clk); addr = a; rdEn = 1'b1;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic tickN(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic capture(logic [4:0] m, logic [15:0] v);
    @(negedge clk); capStb = m; capVal = v;
    @(negedge clk); capStb = '0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL all watchdog: act=timeout exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    checkEq("R1 pwmOut", {15'd0, pwmOut}, 16'd0);
    checkEq("R1 irq", {15'd0, irq}, 16'd0);
    rdReg(4'd0, 16'h0000, "R1 ctrl");
    rdReg(4'd3, 16'h0000, "R1 count");
    rdReg(4'd4, 16'h0000, "R1 status");

    // R2 count gating by run bit and tick
    tickN(3);
    rdReg(4'd3, 16'd0, "R2 no run");
    wrReg(4'd0, 16'h0001);
    repeat (3) @(negedge clk);
    rdReg(4'd3, 16'd0, "R2 no tick");
    tickN(4);
    rdReg(4'd3, 16'd4, "R2 four ticks");

    // R12 register access
    wrReg(4'd3, 16'h0100);
    rdReg(4'd3, 16'h0100, "R12 count load");
    wrReg(4'd2, 16'd5);
    rdReg(4'd2, 16'd5, "R12 cmp1");

    // R3 / R4 / R8 PWM waveform, period 6, off time 2
    wrReg(4'd3, 16'd0);
    wrReg(4'd1, 16'd1);
    wrReg(4'd4, 16'h00FF);
    wrReg(4'd0, 16'h0037);
    checkEq("R4 start low", {15'd0, pwmOut}, 16'd0);
    for (int k = 1; k <= 12; k++) begin
      tickN(1);
      checkEq($sformatf("R4 pwm tick %0d", k), {15'd0, pwmOut},
              {15'd0, ((k % 6) >= 2)});
    end
    rdReg(4'd3, 16'd0, "R3 period wrap");
    rdReg(4'd4, 16'h0003, "R8 compare flags");

    // R11 interrupt masking and level
    checkEq("R11 masked", {15'd0, irq}, 16'd0);
    wrReg(4'd5, 16'h0002);
    checkEq("R11 enabled", {15'd0, irq}, 16'd1);
    wrReg(4'd4, 16'h0002);
    checkEq("R11 cleared", {15'd0, irq}, 16'd0);
    rdReg(4'd4, 16'h0001, "R10 partial clear");
    wrReg(4'd5, 16'h0001);
    checkEq("R11 other flag", {15'd0, irq}, 16'd1);
    wrReg(4'd5, 16'h0000);
    checkEq("R11 disabled", {15'd0, irq}, 16'd0);
    wrReg(4'd4, 16'h00FF);

    // R5 toggle on compare 0, no action on compare 1
    wrReg(4'd1, 16'd0);
    wrReg(4'd2, 16'd3);
    wrReg(4'd0, 16'h001F);
    tickN(1);
    checkEq("R5 toggle up", {15'd0, pwmOut}, 16'd1);
    tickN(3);
    checkEq("R5 none holds", {15'd0, pwmOut}, 16'd1);
    tickN(1);
    checkEq("R5 toggle down", {15'd0, pwmOut}, 16'd0);

    // R5 both match: compare 1 (high) beats compare 0 (low)
    wrReg(4'd1, 16'd3);
    wrReg(4'd0, 16'h004F);
    tickN(2);
    checkEq("R5 before match", {15'd0, pwmOut}, 16'd0);
    tickN(1);
    checkEq("R5 cmp1 wins", {15'd0, pwmOut}, 16'd1);

    // R6 PWM off: output holds, counter free runs past compare 1
    wrReg(4'd0, 16'h0001);
    tickN(6);
    checkEq("R6 hold", {15'd0, pwmOut}, 16'd1);
    rdReg(4'd3, 16'd6, "R3 free run");

    // R7 overflow
    wrReg(4'd4, 16'h00FF);
    wrReg(4'd3, 16'hFFFE);
    tickN(1);
    rdReg(4'd4, 16'h0000, "R7 before wrap");
    tickN(1);
    rdReg(4'd3, 16'h0000, "R7 wrapped");
    rdReg(4'd4, 16'h0004, "R7 ovf set");
    wrReg(4'd4, 16'h00FF);
    wrReg(4'd0, 16'h0005);
    wrReg(4'd3, 16'hFFFF);
    tickN(1);
    rdReg(4'd3, 16'h0000, "R7 clr wrap");
    rdReg(4'd4, 16'h0000, "R7 no ovf in clear mode");

    // R9 capture
    wrReg(4'd4, 16'h00FF);
    capture(5'b00100, 16'hBEEF);
    rdReg(4'd10, 16'hBEEF, "R9 cap2 value");
    rdReg(4'd4, 16'h0020, "R9 cap2 flag");
    capture(5'b10001, 16'h1234);
    rdReg(4'd8, 16'h1234, "R9 cap0 value");
    rdReg(4'd12, 16'h1234, "R9 cap4 value");
    rdReg(4'd10, 16'hBEEF, "R9 cap2 kept");
    rdReg(4'd4, 16'h00A8, "R9 multi flags");

    // R10 event beats same-cycle clear
    wrReg(4'd4, 16'h00FF);
    rdReg(4'd4, 16'h0000, "R10 all cleared");
    @(negedge clk);
    addr = 4'd4; wrData = 16'h0008; wrEn = 1'b1;
    capStb = 5'b00001; capVal = 16'h7777;
    @(negedge clk);
    wrEn = 1'b0; capStb = '0;
    rdReg(4'd4, 16'h0008, "R10 event wins");
    checkEq("R11 no enable", {15'd0, irq}, 16'd0);
    wrReg(4'd4, 16'h0008);
    rdReg(4'd4, 16'h0000, "R10 later clear");

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule